// File: doc/BRIEF.md
# Triggered Sample Capture Controller with Feedback Bank Inversion

This block decides which samples of a continuous stream are written into an external capture buffer, and when they are written. Software arms it and selects the trigger source, either internal or external. On the first rising edge of that source while armed, the block starts a run. Every (N+1)-th valid sample is then written to consecutive buffer addresses until the programmed record length is reached. The capture decimation is set separately from any decimation in the processing path.

A run can also drive a transient growth and damping experiment. With the experiment enabled, a hold-off phase comes first. For a programmed number of valid samples, the feedback coefficient bank select is inverted and nothing is stored. Capture then starts with the inversion still active. The inversion ends at the exact write where the programmed growth span, counted in groups of four stored samples, runs out. The buffer therefore records the loop both while the wrong bank is applied and after the normal bank returns.

When a run finishes, a done flag is set and held. Software clears it, re-arms the block, or, in auto re-arm mode, acknowledges a readout to arm the next run. All run parameters are captured at the trigger, so software may reprogram them while a run is in progress without affecting that run.

Top module: `acq_capture_ctrl`

## Requirements
- R1: After reset, `mem_we`, `armed`, `done` and `bank_inv` are all low and the block is idle.
- R2: A one-cycle `arm_req` seen while idle or done makes `armed` high from the next cycle and clears `done`. `arm_req` has no effect during hold-off or capture.
- R3: `trig_src_ext`=0 selects `trig_int` and 1 selects `trig_ext`. Only a rising edge of the selected source starts a run, and only while armed. Edges on the other source, and any edge while idle, leave the state unchanged.
- R4: With `dec_ratio`=F, capture stores the first valid sample of the capture phase and then every (F+1)-th valid sample after it. Cycles with `smp_vld` low are not counted.
- R5: A run writes exactly min(`rec_len`, 2^AW) samples, to addresses 0, 1, 2, ... in order. Each write appears as a one-cycle `mem_we` in the cycle after its sample, with `mem_wdata` equal to that sample. `rec_len`=0 writes nothing.
- R6: With `grow_en`=1 and `holdoff`=H>0, the first H valid samples after the trigger are not stored, and `bank_inv` is high throughout that phase. With `grow_en`=0 the hold-off value is ignored and capture starts at once.
- R7: During capture with `grow_en`=1, `bank_inv` stays high until 4·`grow_len` samples have been stored. It falls in the same cycle as the write that completes that count. At write j (0-based), `bank_inv` equals (j+1 < 4·`grow_len`) and (j+1 < record length).
- R8: `bank_inv` is never high outside hold-off or capture, and never high in a run triggered with `grow_en`=0.
- R9: `done` rises together with the last write, or directly after the trigger path when the length is 0. It stays high until `done_clr` (which returns the block to idle), `arm_req`, or, with `rearm_auto`=1, `rd_ack` (both of which return it to armed). With `rearm_auto`=0, `rd_ack` has no effect.
- R10: Decimation, record length, growth enable, growth span and hold-off are taken at the trigger. Changing them during a run does not alter that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld | input | 1 | Sample strobe |
| smp_data | input | DW | Sample value |
| arm_req | input | 1 | Arm pulse |
| trig_src_ext | input | 1 | Trigger source select, 1 = external |
| rearm_auto | input | 1 | Re-arm after each readout acknowledge |
| trig_int | input | 1 | Internal trigger |
| trig_ext | input | 1 | External trigger |
| dec_ratio | input | DECW | Capture decimation minus one |
| rec_len | input | AW+1 | Samples per run (clamped to 2^AW) |
| grow_en | input | 1 | Enable bank inversion experiment |
| grow_len | input | AW-1 | Growth span in units of 4 stored samples |
| holdoff | input | HOW | Valid samples of inversion before capture |
| rd_ack | input | 1 | Readout acknowledge pulse |
| done_clr | input | 1 | Clear done, return to idle |
| mem_we | output | 1 | Buffer write enable |
| mem_addr | output | AW | Buffer write address |
| mem_wdata | output | DW | Buffer write data |
| armed | output | 1 | Waiting for trigger |
| done | output | 1 | Run complete |
| bank_inv | output | 1 | Invert feedback bank select |

## Verification
The hardest case to reach is the cycle where several counters meet on one edge. This happens at the change from hold-off to capture, and when the growth span runs out at the same write that ends the record. In that cycle the decimation phase, the inversion drop and the done flag must all agree. The stimulus sweeps decimation ratios, record lengths below, equal to and above the buffer depth, and growth spans shorter than, equal to and longer than the record, with and without hold-off. It numbers the valid samples after each trigger, so the expected data and the expected inversion level can be computed for every write. A subset of runs rewrites every configuration input and pulses arm just after the trigger, to show the run keeps the values taken at the trigger.

// File: rtl/acq_pkg.sv
`timescale 1ns/1ps
package acq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ARMED = 3'd1,
        ST_HOLD  = 3'd2,
        ST_CAPT  = 3'd3,
        ST_DONE  = 3'd4
    } acq_state_e;
endpackage

// File: rtl/acq_trig.sv
`timescale 1ns/1ps
// Rising-edge detection on both trigger sources, then source selection.
module acq_trig (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_int,
    input  logic trig_ext,
    input  logic sel_ext,
    output logic hit
);
    localparam int NSRC = 2;

    logic [NSRC-1:0] lvl;
    logic [NSRC-1:0] prev_d, prev_q;
    logic [NSRC-1:0] edge_v;

    assign lvl = {trig_ext, trig_int};

    genvar gi;
    generate
        for (gi = 0; gi < NSRC; gi++) begin : g_src
            assign edge_v[gi] = lvl[gi] & ~prev_q[gi];
        end
    endgenerate

    always_comb begin
        prev_d = lvl;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    assign hit = sel_ext ? edge_v[1] : edge_v[0];
endmodule

// File: rtl/acq_decim.sv
`timescale 1ns/1ps
// Decimation phase counter: take is high on the sample to be stored.
module acq_decim #(
    parameter int DECW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hold,
    input  logic            vld,
    input  logic [DECW-1:0] ratio_m1,
    output logic            take
);
    logic [DECW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (hold)
            cnt_d = '0;
        else if (vld)
            cnt_d = (cnt_q == ratio_m1) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign take = vld && !hold && (cnt_q == '0);
endmodule

// File: rtl/acq_capture_ctrl.sv
`timescale 1ns/1ps
module acq_capture_ctrl
    import acq_pkg::*;
#(
    parameter int DW   = 16,
    parameter int AW   = 10,
    parameter int DECW = 8,
    parameter int HOW  = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            smp_vld,
    input  logic [DW-1:0]   smp_data,
    input  logic            arm_req,
    input  logic            trig_src_ext,
    input  logic            rearm_auto,
    input  logic            trig_int,
    input  logic            trig_ext,
    input  logic [DECW-1:0] dec_ratio,
    input  logic [AW:0]     rec_len,
    input  logic            grow_en,
    input  logic [AW-2:0]   grow_len,
    input  logic [HOW-1:0]  holdoff,
    input  logic            rd_ack,
    input  logic            done_clr,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    output logic            armed,
    output logic            done,
    output logic            bank_inv
);
    localparam int          DEPTH   = 1 << AW;
    localparam logic [AW:0] DEPTH_V = (AW+1)'(DEPTH);

    typedef struct packed {
        acq_state_e      st;
        logic [AW:0]     wcnt;
        logic [HOW-1:0]  hcnt;
        logic [AW:0]     len;
        logic [DECW-1:0] dec;
        logic            ge;
        logic [AW:0]     glim;
        logic [HOW-1:0]  ho;
        logic            we;
        logic [AW-1:0]   addr;
        logic [DW-1:0]   wdata;
        logic            inv;
    } regs_t;

    regs_t r_d, r_q;
    logic  trig_hit;
    logic  take;

    acq_trig u_trig (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig_int (trig_int),
        .trig_ext (trig_ext),
        .sel_ext  (trig_src_ext),
        .hit      (trig_hit)
    );

    acq_decim #(.DECW(DECW)) u_decim (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (r_q.st != ST_CAPT),
        .vld      (smp_vld),
        .ratio_m1 (r_q.dec),
        .take     (take)
    );

    always_comb begin
        r_d    = r_q;
        r_d.we = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (arm_req) r_d.st = ST_ARMED;
            end
            ST_ARMED: begin
                if (trig_hit) begin
                    r_d.len  = (rec_len > DEPTH_V) ? DEPTH_V : rec_len;
                    r_d.dec  = dec_ratio;
                    r_d.ge   = grow_en;
                    r_d.glim = {grow_len, 2'b00};
                    r_d.ho   = holdoff;
                    r_d.wcnt = '0;
                    r_d.hcnt = '0;
                    r_d.st   = (grow_en && holdoff != '0) ? ST_HOLD : ST_CAPT;
                end
            end
            ST_HOLD: begin
                if (smp_vld) begin
                    if (r_q.hcnt == r_q.ho - HOW'(1)) r_d.st = ST_CAPT;
                    else                               r_d.hcnt = r_q.hcnt + HOW'(1);
                end
            end
            ST_CAPT: begin
                if (r_q.wcnt >= r_q.len) begin
                    r_d.st = ST_DONE;
                end else if (take) begin
                    r_d.we    = 1'b1;
                    r_d.addr  = r_q.wcnt[AW-1:0];
                    r_d.wdata = smp_data;
                    r_d.wcnt  = r_q.wcnt + 1'b1;
                    if (r_q.wcnt + 1'b1 == r_q.len) r_d.st = ST_DONE;
                end
            end
            ST_DONE: begin
                if (arm_req || (rearm_auto && rd_ack)) r_d.st = ST_ARMED;
                else if (done_clr)                     r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
        r_d.inv = r_d.ge && ((r_d.st == ST_HOLD) ||
                             ((r_d.st == ST_CAPT) && (r_d.wcnt < r_d.glim)));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_we    = r_q.we;
    assign mem_addr  = r_q.addr;
    assign mem_wdata = r_q.wdata;
    assign armed     = (r_q.st == ST_ARMED);
    assign done      = (r_q.st == ST_DONE);
    assign bank_inv  = r_q.inv;
endmodule

// File: rtl/acq_capture_chk.sv
`timescale 1ns/1ps
module acq_capture_chk
    import acq_pkg::*;
#(
    parameter int AW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input acq_state_e    st,
    input logic          ge_lat,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic          armed,
    input logic          done,
    input logic          bank_inv,
    input logic          arm_req,
    input logic          done_clr,
    input logic          rd_ack,
    input logic          rearm_auto
);
    AST_INV_SCOPE: assert property (@(posedge clk) disable iff (!rst_n)
        bank_inv |-> (st == ST_HOLD || st == ST_CAPT)); // R8
    AST_INV_NEEDS_GROW: assert property (@(posedge clk) disable iff (!rst_n)
        bank_inv |-> ge_lat); // R8
    AST_WE_FROM_CAPT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> $past(st) == ST_CAPT); // R5
    AST_ADDR_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (!mem_we || mem_addr == AW'($past(mem_addr) + 1'b1))); // R5
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !done_clr && !arm_req && !(rearm_auto && rd_ack)) |=> done); // R9
    AST_DONE_FROM_CAPT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(st) == ST_CAPT); // R9
    AST_IDLE_NO_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && !arm_req) |=> st == ST_IDLE); // R3
    AST_ARMED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (!done && !bank_inv && !mem_we)); // R2
endmodule

bind acq_capture_ctrl acq_capture_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .st         (r_q.st),
    .ge_lat     (r_q.ge),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .armed      (armed),
    .done       (done),
    .bank_inv   (bank_inv),
    .arm_req    (arm_req),
    .done_clr   (done_clr),
    .rd_ack     (rd_ack),
    .rearm_auto (rearm_auto)
);

// File: tb/acq_capture_ctrl_tb.sv
`timescale 1ns/1ps
module acq_capture_ctrl_tb;
    localparam int DW = 8, AW = 4, DECW = 3, HOW = 32;
    localparam int DEPTH = 1 << AW;
    localparam int LIMIT = 190000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic smp_vld = 0; logic [DW-1:0] smp_data = '0;
    logic arm_req = 0, trig_src_ext = 0, rearm_auto = 0, trig_int = 0, trig_ext = 0;
    logic [DECW-1:0] dec_ratio = '0; logic [AW:0] rec_len = '0;
    logic grow_en = 0; logic [AW-2:0] grow_len = '0; logic [HOW-1:0] holdoff = '0;
    logic rd_ack = 0, done_clr = 0;
    logic mem_we, armed, done, bank_inv;
    logic [AW-1:0] mem_addr; logic [DW-1:0] mem_wdata;

    int total = 0, bad = 0, cyc = 0;
    int e_L = 0, e_H = 0, e_dec = 0, e_G = 0, e_ge = 0, wseen = 0;

    always #2.5 clk = ~clk;

    acq_capture_ctrl #(.DW(DW), .AW(AW), .DECW(DECW), .HOW(HOW)) u_dut (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_data(smp_data),
        .arm_req(arm_req), .trig_src_ext(trig_src_ext), .rearm_auto(rearm_auto),
        .trig_int(trig_int), .trig_ext(trig_ext), .dec_ratio(dec_ratio),
        .rec_len(rec_len), .grow_en(grow_en), .grow_len(grow_len), .holdoff(holdoff),
        .rd_ack(rd_ack), .done_clr(done_clr), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .armed(armed), .done(done), .bank_inv(bank_inv));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // Write monitor: data, address and inversion level per write (R4 R5 R7)
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            chk(wseen < e_L, "R5 write count", wseen + 1, e_L);
            chk(int'(mem_addr) == wseen, "R5 addr", int'(mem_addr), wseen);
            chk(mem_wdata == DW'(e_H + wseen * (e_dec + 1)), "R4 data",
                int'(mem_wdata), (e_H + wseen * (e_dec + 1)) % 256);
            chk(bank_inv == (e_ge != 0 && wseen + 1 < e_G && wseen + 1 < e_L),
                "R7 inv at write", int'(bank_inv),
                int'(e_ge != 0 && wseen + 1 < e_G && wseen + 1 < e_L));
            wseen++;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == LIMIT) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, LIMIT);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic run(input int dec, input int rec, input int ge, input int gl,
                       input int ho, input int gap, input int sel, input bit scr);
        int nsmp;
        e_dec = dec; e_L = (rec > DEPTH) ? DEPTH : rec;
        e_ge = ge; e_G = gl * 4; e_H = ge ? ho : 0; wseen = 0;
        dec_ratio = DECW'(dec); rec_len = (AW+1)'(rec); grow_en = ge[0];
        grow_len = (AW-1)'(gl); holdoff = HOW'(ho); trig_src_ext = sel[0];
        if (!armed) begin
            arm_req = 1; @(negedge clk); arm_req = 0;
        end
        chk(armed == 1 && done == 0, "R2 armed", int'(armed), 1);
        // wrong-source edge must be ignored (R3)
        if (sel != 0) trig_int = 1; else trig_ext = 1;
        @(negedge clk); trig_int = 0; trig_ext = 0;
        @(negedge clk);
        chk(armed == 1, "R3 other source ignored", int'(armed), 1);
        if (sel != 0) trig_ext = 1; else trig_int = 1;
        @(negedge clk); trig_int = 0; trig_ext = 0;
        chk(armed == 0, "R3 trigger taken", int'(armed), 0);
        if (scr) begin // R10 and R2: change everything, pulse arm
            rec_len = 1; dec_ratio = '1; grow_en = ~grow_en; grow_len = '1;
            holdoff = 7; arm_req = 1;
        end
        nsmp = e_H + (e_L + 2) * (dec + 1) + 2;
        for (int k = 0; k < nsmp; k++) begin
            smp_vld = 1; smp_data = DW'(k);
            if (k < e_H) chk(bank_inv == 1, "R6 inv during hold-off", int'(bank_inv), 1);
            @(negedge clk); arm_req = 0;
            if (gap != 0) begin smp_vld = 0; @(negedge clk); end
        end
        smp_vld = 0;
        repeat (3) @(negedge clk);
        chk(done == 1, "R9 done set", int'(done), 1);
        chk(wseen == e_L, "R5 total writes", wseen, e_L);
        chk(bank_inv == 0, "R8 inv off after run", int'(bank_inv), 0);
        rd_ack = 1; @(negedge clk); rd_ack = 0;
        if (rearm_auto) begin
            chk(armed == 1 && done == 0, "R9 re-arm on ack", int'(armed), 1);
        end else begin
            chk(done == 1, "R9 ack ignored single shot", int'(done), 1);
            repeat (4) @(negedge clk);
            chk(done == 1, "R9 done held", int'(done), 1);
            done_clr = 1; @(negedge clk); done_clr = 0;
            chk(done == 0 && armed == 0, "R9 clear to idle", int'(done), 0);
        end
        e_L = 0;
    endtask

    initial begin
        int cfg_ge[5] = '{0, 1, 1, 1, 1};
        int cfg_gl[5] = '{2, 0, 1, 3, 4};
        int cfg_ho[5] = '{3, 2, 0, 5, 1};
        int lens[5]   = '{0, 1, 5, 16, 21};
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(mem_we == 0 && armed == 0 && done == 0 && bank_inv == 0,
            "R1 reset state", int'({mem_we, armed, done, bank_inv}), 0);
        // Triggers and samples while idle do nothing (R3)
        trig_int = 1; @(negedge clk); trig_int = 0; trig_ext = 1; @(negedge clk); trig_ext = 0;
        for (int k = 0; k < 6; k++) begin smp_vld = 1; smp_data = DW'(k); @(negedge clk); end
        smp_vld = 0;
        chk(armed == 0 && done == 0 && bank_inv == 0, "R3 idle trigger ignored",
            int'({armed, done, bank_inv}), 0);
        // Sweep
        for (int d = 0; d < 4; d++)
            for (int li = 0; li < 5; li++)
                for (int c = 0; c < 5; c++)
                    for (int g = 0; g < 2; g++)
                        run(d, lens[li], cfg_ge[c], cfg_gl[c], cfg_ho[c], g, g ^ (d & 1),
                            (d == 1 && g == 1));
        // Auto re-arm: two runs chained by readout acknowledge (R9)
        rearm_auto = 1;
        run(1, 3, 1, 1, 2, 0, 0, 0);
        chk(armed == 1, "R9 chained armed", int'(armed), 1);
        rearm_auto = 0;
        run(0, 4, 0, 0, 0, 0, 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule